// File: doc/BRIEF.md
# Slave-Mode Serial Audio Transmitter

This block turns parallel stereo PCM samples into a serial bit stream on one data line. It is a timing slave. The bit clock and the word-select (frame sync) line both come from outside and are only sampled. The sole output it drives on the audio side is the serial data bit. Both external signals are brought into a faster system clock domain through flop synchronisers. All frame tracking runs in that domain.

A stereo pair is offered on a valid/ready handshake. The pair is taken at the moment the left channel word starts. If no pair is waiting at that moment, the previous pair is sent again and a one-cycle underrun pulse is raised.

A static 4-bit format code selects the frame format:
- `0110` selects left-justified.
- Every other code selects I2S.

A static polarity bit selects which bit-clock edge launches data. The block does not assume a fixed number of bit slots per channel. Any slots after the LSB of a word are sent as zero.

Top module: `pcm_serial_tx`

## Requirements
- R1: The serial data output changes only in response to a launch edge of the external bit clock. Each new bit is present no later than 4 system clock cycles after that edge (with `SYNC_STAGES` = 2). A receiver sampling half a bit period later therefore sees it, provided that half period is at least 7 system clock cycles.
- R2: Each channel word is sent MSB first, `SAMPLE_W` bits down to the LSB. Every further slot before the next channel start is sent as 0.
- R3: With format code `4'b0000` (I2S), word select low marks the left channel. The MSB appears in the second bit slot after a word-select transition. The first slot carries the previous word's LSB when a channel has exactly `SAMPLE_W` slots, and 0 otherwise.
- R4: With format code `4'b0110` (left-justified), word select high marks the left channel. The MSB appears in the first bit slot after a word-select transition.
- R5: Any format code other than `4'b0110` behaves exactly as I2S.
- R6: With `edge_inv_i` = 0 the falling bit-clock edge launches data. With `edge_inv_i` = 1 the rising edge launches data.
- R7: Each frame sends the left word and then the right word of one pair. `pair_ready_o` is high for exactly one system cycle, at the left-word load. A pair transfers when `pair_valid_i` and `pair_ready_o` are both high, so one transfer occurs per frame.
- R8: If `pair_valid_i` is low at the left-word load, the previously held pair is sent again, the offered data are ignored, and `underrun_o` is high for the following single cycle.
- R9: Correct output for any number of bit slots per channel of at least `SAMPLE_W` (for example 16 and 20 with a 16-bit word).
- R10: After reset, `ser_data_o`, `pair_ready_o` and `underrun_o` are 0. Data stays 0 until the first word-select transition that is observed after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times the bit clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | External serial bit clock |
| word_sel_i | input | 1 | External word-select / frame sync |
| fmt_code_i | input | 4 | Frame format code (`0110` left-justified, else I2S) |
| edge_inv_i | input | 1 | 0: falling edge launches data; 1: rising edge launches data |
| pair_valid_i | input | 1 | A stereo pair is offered |
| pair_left_i | input | SAMPLE_W | Left sample of the offered pair |
| pair_right_i | input | SAMPLE_W | Right sample of the offered pair |
| pair_ready_o | output | 1 | One-cycle accept strobe at the left-word load |
| underrun_o | output | 1 | One-cycle pulse when no pair was offered at the left-word load |
| ser_data_o | output | 1 | Serial audio data |

## Verification
In I2S mode, two events fall on the same bit-clock launch edge: the tail of the previous channel word and the detection of the next channel's boundary. When a channel has exactly `SAMPLE_W` slots, the LSB of the previous word must be shifted out in the same cycle that the next load is being armed.

The bench provokes this by sweeping slot counts of exactly 16 and of 20 across all formats and both edge polarities. In the exact-fit case it expects the previous word's LSB in slot 0; in the padded case it expects 0.

A second collision is the handshake and the underrun decision, both taken at the left load. A frame with valid held low must replay the old pair and raise exactly one underrun pulse while the data offered in that frame are ignored.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

   typedef enum logic {
      FMT_I2S   = 1'b0,
      FMT_LEFTJ = 1'b1
   } frame_fmt_e;

   localparam logic [3:0] CODE_LEFTJ = 4'b0110;

   // Only the left-justified code is special; every other code falls back to I2S.
   function automatic frame_fmt_e decode_fmt(input logic [3:0] code);
      return (code == CODE_LEFTJ) ? FMT_LEFTJ : FMT_I2S;
   endfunction

endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_tx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pcm_tx_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pcm_tx_frame.sv
module pcm_tx_frame
   import pcm_tx_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       bclk_s_i,
   input  logic       ws_s_i,
   input  logic       edge_inv_i,
   input  frame_fmt_e fmt_i,
   output logic       tick_o,
   output logic       load_o,
   output logic       load_left_o
);

   logic bclk_q, tick_q, primed_q, ws_last_q, pend_q, pend_left_q;
   logic edge_raw, boundary, left_lvl;

   // Launch edge chosen by polarity; strobe delayed one cycle so word select has settled.
   assign edge_raw = edge_inv_i ? (bclk_s_i & ~bclk_q) : (~bclk_s_i & bclk_q);
   assign boundary = primed_q && (ws_s_i != ws_last_q);
   assign left_lvl = (fmt_i == FMT_LEFTJ) ? ws_s_i : ~ws_s_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q      <= 1'b0;
         tick_q      <= 1'b0;
         primed_q    <= 1'b0;
         ws_last_q   <= 1'b0;
         pend_q      <= 1'b0;
         pend_left_q <= 1'b0;
      end else begin
         bclk_q <= bclk_s_i;
         tick_q <= edge_raw;
         if (tick_q) begin
            primed_q    <= 1'b1;
            ws_last_q   <= ws_s_i;
            pend_q      <= (fmt_i == FMT_I2S) && boundary;
            pend_left_q <= left_lvl;
         end
      end
   end

   // Left-justified loads on the boundary slot; I2S loads one slot later.
   assign tick_o      = tick_q;
   assign load_o      = tick_q && ((fmt_i == FMT_LEFTJ) ? boundary : pend_q);
   assign load_left_o = (fmt_i == FMT_LEFTJ) ? left_lvl : pend_left_q;

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              sd_o
);

   localparam int CNT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  rem_q;
   logic              sd_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         rem_q <= '0;
         sd_q  <= 1'b0;
      end else if (tick_i) begin
         if (load_i) begin
            sd_q  <= word_i[WORD_W-1];
            sh_q  <= {word_i[WORD_W-2:0], 1'b0};
            rem_q <= CNT_W'(WORD_W - 1);
         end else if (rem_q != '0) begin
            sd_q  <= sh_q[WORD_W-1];
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            rem_q <= rem_q - 1'b1;
         end else begin
            sd_q  <= 1'b0;
         end
      end
   end

   assign sd_o = sd_q;

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
   import pcm_tx_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bit_clk_i,
   input  logic                word_sel_i,
   input  logic [3:0]          fmt_code_i,
   input  logic                edge_inv_i,
   input  logic                pair_valid_i,
   input  logic [SAMPLE_W-1:0] pair_left_i,
   input  logic [SAMPLE_W-1:0] pair_right_i,
   output logic                pair_ready_o,
   output logic                underrun_o,
   output logic                ser_data_o
);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("pcm_serial_tx: SAMPLE_W must be at least 2");
   end

   logic [1:0]          sync_s;
   logic                tick, load, load_left, take;
   logic [SAMPLE_W-1:0] hold_l_q, hold_r_q, word;
   logic                underrun_q;
   frame_fmt_e          fmt;

   assign fmt = decode_fmt(fmt_code_i);

   pcm_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i ({word_sel_i, bit_clk_i}),
      .sync_o  (sync_s)
   );

   pcm_tx_frame u_frame (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bclk_s_i    (sync_s[0]),
      .ws_s_i      (sync_s[1]),
      .edge_inv_i  (edge_inv_i),
      .fmt_i       (fmt),
      .tick_o      (tick),
      .load_o      (load),
      .load_left_o (load_left)
   );

   assign pair_ready_o = load && load_left;
   assign take         = pair_ready_o && pair_valid_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_l_q   <= '0;
         hold_r_q   <= '0;
         underrun_q <= 1'b0;
      end else begin
         underrun_q <= pair_ready_o && !pair_valid_i;
         if (take) begin
            hold_l_q <= pair_left_i;
            hold_r_q <= pair_right_i;
         end
      end
   end

   assign word = load_left ? (take ? pair_left_i : hold_l_q) : hold_r_q;
   assign underrun_o = underrun_q;

   pcm_tx_shift #(.WORD_W(SAMPLE_W)) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .load_i (load),
      .word_i (word),
      .sd_o   (ser_data_o)
   );

endmodule

module pcm_serial_tx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic tick_i,
   input logic ready_i,
   input logic valid_i,
   input logic underrun_i,
   input logic sd_i
);

   assert_sd_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(sd_i));

   assert_ready_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |-> tick_i);

   assert_ready_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |=> !ready_i);

   assert_underrun_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_i |-> $past(ready_i && !valid_i));

   assert_underrun_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_i |=> !underrun_i);

   assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ready_i, underrun_i}));

endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tick_i     (tick),
   .ready_i    (pair_ready_o),
   .valid_i    (pair_valid_i),
   .underrun_i (underrun_o),
   .sd_i       (ser_data_o)
);

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;

   localparam int N    = 16;
   localparam int HALF = 8;

   logic         clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, ws = 1'b0, inv = 1'b0, valid = 1'b0;
   logic [3:0]   code = 4'b0000;
   logic [N-1:0] inl = '0, inr = '0;
   logic         ready, underrun, sd;

   int vectors = 0, fails = 0, accepts = 0, ur_cnt = 0, rdy_cnt = 0, cur_slots = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pcm_serial_tx #(.SAMPLE_W(N), .SYNC_STAGES(2)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .bit_clk_i(bclk), .word_sel_i(ws),
      .fmt_code_i(code), .edge_inv_i(inv), .pair_valid_i(valid),
      .pair_left_i(inl), .pair_right_i(inr), .pair_ready_o(ready),
      .underrun_o(underrun), .ser_data_o(sd)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s code=%b inv=%0d slots=%0d act=%0d exp=%0d",
                  req, code, inv, cur_slots, act, exp);
      end
   endtask

   function automatic logic exp_bit(bit lj, int j, int slots, logic [N-1:0] w, logic [N-1:0] pw);
      if (lj) return (j < N) ? w[N-1-j] : 1'b0;
      if (j == 0) return (slots == N) ? pw[0] : 1'b0;
      return (j <= N) ? w[N-j] : 1'b0;
   endfunction

   function automatic logic [N-1:0] pat(int f, bit right);
      return N'(16'hA5C3 ^ (f * 16'h1357) ^ (right ? 16'h7E81 : 16'h0000));
   endfunction

   // One bit slot: launch edge, sample just before the capture edge, capture edge.
   task automatic slot(input logic ws_val, input logic exp, input string req);
      bclk = inv;
      ws   = ws_val;
      repeat (HALF - 1) @(negedge clk);
      chk(req, int'(sd), int'(exp));
      @(negedge clk);
      bclk = ~inv;
      repeat (HALF) @(negedge clk);
   endtask

   // Port monitor: handshake transfers, ready strobes and underrun pulses.
   initial begin
      forever begin
         @(negedge clk);
         if (ready) rdy_cnt++;
         if (underrun) ur_cnt++;
         if (valid && ready) begin
            accepts++;
            @(posedge clk);
            #1 valid = 1'b0;
         end
      end
   end

   task automatic run_cfg(input logic [3:0] c, input logic iv, input int slots);
      bit           lj;
      logic         lvl_l;
      logic [N-1:0] cur_l, cur_r, prev_r;
      string        tag_l;
      lj        = (c == 4'b0110);
      lvl_l     = lj;
      code      = c;
      inv       = iv;
      cur_slots = slots;
      bclk      = ~iv;
      ws        = ~lvl_l;
      valid     = 1'b0;
      rst_n     = 1'b0;
      repeat (4) @(negedge clk);
      rst_n   = 1'b1;
      accepts = 0; ur_cnt = 0; rdy_cnt = 0;
      repeat (3) @(negedge clk);
      chk("R10 reset data", int'(sd), 0);
      chk("R10 reset ready", int'(ready), 0);
      chk("R10 reset underrun", int'(underrun), 0);
      for (int k = 0; k < 3; k++) slot(~lvl_l, 1'b0, "R10 idle zero");
      tag_l  = lj ? "R4 R1 R6 R9" : ((c == 4'b0000) ? "R3 R1 R6 R9" : "R5 R1 R6 R9");
      cur_l  = '0; cur_r = '0; prev_r = '0;
      for (int f = 0; f < 5; f++) begin
         bit want;
         want = (f != 2);
         inl   = pat(f, 1'b0);
         inr   = pat(f, 1'b1);
         valid = want;
         if (want) begin
            cur_l = pat(f, 1'b0);
            cur_r = pat(f, 1'b1);
         end
         for (int j = 0; j < slots; j++)
            slot(lvl_l, exp_bit(lj, j, slots, cur_l, prev_r), tag_l);
         for (int j = 0; j < slots; j++)
            slot(~lvl_l, exp_bit(lj, j, slots, cur_r, cur_l), "R2 R7 right word");
         prev_r = cur_r;
      end
      chk("R7 transfers", accepts, 4);
      chk("R7 ready strobes", rdy_cnt, 5);
      chk("R8 underrun pulses", ur_cnt, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] codes [3];
      codes[0] = 4'b0000;
      codes[1] = 4'b0110;
      codes[2] = 4'b1010;
      for (int ci = 0; ci < 3; ci++)
         for (int e = 0; e < 2; e++)
            for (int s = 0; s < 2; s++)
               run_cfg(codes[ci], e[0], (s == 0) ? N : N + 4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule